// File: doc/BRIEF.md
# Voice Loop-Stop Controller

This block watches the loop point of 64 playback voices that a sample engine services one after another, one voice per slot, 64 slots per sample period. On each slot the engine presents the serviced voice number, that voice's 24-bit current address, its loop end address and its current pitch. When the address has reached the loop end, the block records a loop event for the voice. It marks the voice pending and raises a per-voice loop flag that lasts until the voice's next slot. If stopping on loop is enabled for that voice, it also latches a stop bit, and the stop bit forces the pitch handed back to the engine to zero.

Software controls the block through a single-cycle register write port and a combinational read port. Each per-voice state vector is held as 32-bit words. The interrupt enables and the stop-on-loop enables are plain read/write. Pending bits are write-one-to-clear. Stop bits can be written, but only where the matching enable is 1. A summary word gives an interrupt flag and the number of the highest voice that is both pending and enabled. The stop bit stays set when later addresses fall back below the loop end. It is released only by clearing it or by clearing its enable. Enable writes are not held back to a sample boundary, so the next slot already uses the new value.

Top module: `vlc_loop_ctrl`

## Requirements
- R1: After reset all enable, pending, stop and loop-flag bits are 0, `irq` is 0 and every register reads 0.
- R2: On a slot with `slot_vld`=1 and unsigned `slot_addr` >= `slot_loop_end`, the pending bit of `slot_voice` reads 1 from the next cycle; with `slot_addr` < `slot_loop_end` it is left unchanged.
- R3: A looping slot whose voice has its stop-on-loop enable at 1 sets that voice's stop bit, and `slot_pitch_out` is 0 with `slot_stopped`=1 in that same slot; with the enable at 0 no stop bit is set and `slot_pitch_out` equals `slot_pitch_in`.
- R4: A set stop bit keeps `slot_pitch_out` at 0 on later slots of that voice whatever the addresses are; it is released only by writing 0 to it or by writing 0 to its enable bit.
- R5: A stop-bit write sets only the bits whose stop-on-loop enable is 1; the others read back 0.
- R6: An enable write accepted in cycle N is used by a slot presented in cycle N+1.
- R7: A voice's loop flag (`loop_flags[v]`) goes to 1 after a looping slot of that voice and stays 1 until the voice's next slot, after which it follows that slot's loop result.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it; a loop event in the same cycle as the clear wins and leaves the bit at 1.
- R9: `irq` is 1 exactly when some voice is both pending and interrupt-enabled; the summary word carries `irq` in bit 6 and the highest such voice number in bits 5:0, and reads 0 when none is.
- R10: Register select (`wr_sel`/`rd_sel`): 0/1 interrupt enables, 2/3 pending, 4/5 stop-on-loop enables, 6/7 stop bits, 8 summary; the even select holds voices 0-31 at bit v, the odd select voices 32-63 at bit v-32. Selects 8 to 15 ignore writes and 9 to 15 read 0.
- R11: A slot with `slot_vld`=0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | A voice is serviced in this cycle |
| slot_voice | input | 6 | Number of the serviced voice |
| slot_addr | input | 24 | Current address of the serviced voice |
| slot_loop_end | input | 24 | Loop end address of the serviced voice |
| slot_pitch_in | input | 16 | Pitch of the serviced voice |
| slot_pitch_out | output | 16 | Pitch after the stop force |
| slot_stopped | output | 1 | Serviced voice is held stopped |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for the read |
| rd_data | output | 32 | Read data |
| loop_flags | output | 64 | Per-voice loop flags |
| irq | output | 1 | Enabled pending voice present |

## Verification
The loop compare is driven with addresses equal to the loop end, one below it, at zero and at the all-ones top, and on both sides of bit 23, which separates an unsigned compare from a signed or off-by-one one. Voices at both ends of both words are used so that a wrong word or bit position shows. Stop behaviour is driven with the enable on and off, with addresses dropping back below the loop end, and with a write in the cycle right before a slot, which separates a latched, immediately-effective stop from a level or delayed one. The summary is driven with two enabled voices in different words and then with pending voices whose interrupt enable is off, which separates highest-voice priority and enable masking from a plain OR of the pending bits.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  localparam int KIND_W = 3;

  // Upper field of a register select: which per-voice vector is addressed.
  typedef enum logic [KIND_W-1:0] {
    KIND_IE   = 3'd0,
    KIND_PEND = 3'd1,
    KIND_STEN = 3'd2,
    KIND_STOP = 3'd3,
    KIND_STAT = 3'd4
  } reg_kind_e;

endpackage

// File: rtl/vlc_slot_eval.sv
module vlc_slot_eval #(
  parameter int NUM_VOICES = 64,
  parameter int ADDR_W     = 24,
  parameter int VOICE_W    = 6
) (
  input  logic                  slot_vld,
  input  logic [VOICE_W-1:0]    slot_voice,
  input  logic [ADDR_W-1:0]     slot_addr,
  input  logic [ADDR_W-1:0]     slot_loop_end,
  output logic [NUM_VOICES-1:0] svc_vec,
  output logic [NUM_VOICES-1:0] hit_vec
);

  logic passed;

  // Unsigned compare: reaching the loop end counts as a loop.
  assign passed = (slot_addr >= slot_loop_end);

  generate
    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_dec
      assign svc_vec[v] = slot_vld && (slot_voice == VOICE_W'(v));
      assign hit_vec[v] = svc_vec[v] && passed;
    end
  endgenerate

endmodule

// File: rtl/vlc_prio_enc.sv
module vlc_prio_enc #(
  parameter int WIDTH = 64,
  parameter int IDX_W = 6
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Highest set bit wins: later iterations override earlier ones.
  always_comb begin
    idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/vlc_voice_bank.sv
module vlc_voice_bank
  import vlc_pkg::*;
#(
  parameter int NUM_VOICES = 64,
  parameter int DATA_W     = 32,
  parameter int WIDX_W     = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [KIND_W-1:0]     wr_kind,
  input  logic [WIDX_W-1:0]     wr_word,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_VOICES-1:0] svc_vec,
  input  logic [NUM_VOICES-1:0] hit_vec,
  output logic [NUM_VOICES-1:0] ie_q,
  output logic [NUM_VOICES-1:0] pend_q,
  output logic [NUM_VOICES-1:0] sten_q,
  output logic [NUM_VOICES-1:0] stop_q,
  output logic [NUM_VOICES-1:0] flag_q
);

  localparam int NUM_WORDS = NUM_VOICES / DATA_W;

  logic [NUM_VOICES-1:0] wmask, wdat;
  logic [NUM_VOICES-1:0] m_ie, m_pend, m_sten, m_stop;
  logic [NUM_VOICES-1:0] ie_n, pend_n, sten_n, stop_n, flag_n;
  logic                  upd;

  // Spread the 32-bit write over the addressed word lane.
  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
      assign wmask[w*DATA_W +: DATA_W] = {DATA_W{wr_en && (wr_word == WIDX_W'(w))}};
      assign wdat[w*DATA_W +: DATA_W]  = wr_data;
    end
  endgenerate

  assign m_ie   = (wr_kind == KIND_IE)   ? wmask : '0;
  assign m_pend = (wr_kind == KIND_PEND) ? wmask : '0;
  assign m_sten = (wr_kind == KIND_STEN) ? wmask : '0;
  assign m_stop = (wr_kind == KIND_STOP) ? wmask : '0;

  always_comb begin
    ie_n   = (ie_q   & ~m_ie)   | (wdat & m_ie);
    sten_n = (sten_q & ~m_sten) | (wdat & m_sten);
    // Write-one-to-clear; a loop event in the same cycle takes precedence.
    pend_n = (pend_q & ~(wdat & m_pend)) | hit_vec;
    // Stop bits latch on loop (old enable), take writes, and never outlive their enable.
    stop_n = ((stop_q & ~m_stop) | (wdat & m_stop) | (hit_vec & sten_q)) & sten_n;
    // A flag lives from the looping slot to the voice's next slot.
    flag_n = (flag_q & ~svc_vec) | hit_vec;
  end

  assign upd = wr_en | (|svc_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      pend_q <= '0;
      sten_q <= '0;
      stop_q <= '0;
      flag_q <= '0;
    end else if (upd) begin
      ie_q   <= ie_n;
      pend_q <= pend_n;
      sten_q <= sten_n;
      stop_q <= stop_n;
      flag_q <= flag_n;
    end
  end

endmodule

// File: rtl/vlc_loop_ctrl.sv
module vlc_loop_ctrl
  import vlc_pkg::*;
#(
  parameter int NUM_VOICES = 64,
  parameter int ADDR_W     = 24,
  parameter int PITCH_W    = 16,
  parameter int DATA_W     = 32,
  localparam int VOICE_W   = $clog2(NUM_VOICES),
  localparam int NUM_WORDS = NUM_VOICES / DATA_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int SEL_W     = KIND_W + WIDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_vld,
  input  logic [VOICE_W-1:0]    slot_voice,
  input  logic [ADDR_W-1:0]     slot_addr,
  input  logic [ADDR_W-1:0]     slot_loop_end,
  input  logic [PITCH_W-1:0]    slot_pitch_in,
  output logic [PITCH_W-1:0]    slot_pitch_out,
  output logic                  slot_stopped,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_VOICES-1:0] loop_flags,
  output logic                  irq
);

  logic [NUM_VOICES-1:0] svc_vec, hit_vec;
  logic [NUM_VOICES-1:0] ie_q, pend_q, sten_q, stop_q;
  logic [VOICE_W-1:0]    top_idx;
  logic [KIND_W-1:0]     wr_kind, rd_kind;
  logic [WIDX_W-1:0]     wr_word, rd_word;
  logic [DATA_W-1:0]     status_word;

  assign wr_kind = wr_sel[SEL_W-1:WIDX_W];
  assign wr_word = wr_sel[WIDX_W-1:0];
  assign rd_kind = rd_sel[SEL_W-1:WIDX_W];
  assign rd_word = rd_sel[WIDX_W-1:0];

  vlc_slot_eval #(
    .NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W), .VOICE_W(VOICE_W)
  ) u_eval (
    .slot_vld(slot_vld), .slot_voice(slot_voice), .slot_addr(slot_addr),
    .slot_loop_end(slot_loop_end), .svc_vec(svc_vec), .hit_vec(hit_vec)
  );

  vlc_voice_bank #(
    .NUM_VOICES(NUM_VOICES), .DATA_W(DATA_W), .WIDX_W(WIDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_word(wr_word),
    .wr_data(wr_data), .svc_vec(svc_vec), .hit_vec(hit_vec),
    .ie_q(ie_q), .pend_q(pend_q), .sten_q(sten_q), .stop_q(stop_q), .flag_q(loop_flags)
  );

  vlc_prio_enc #(
    .WIDTH(NUM_VOICES), .IDX_W(VOICE_W)
  ) u_prio (
    .vec(pend_q & ie_q), .any(irq), .idx(top_idx)
  );

  // The looping slot itself already runs at zero pitch when its enable is on.
  assign slot_stopped   = |((stop_q | (hit_vec & sten_q)) & svc_vec);
  assign slot_pitch_out = slot_stopped ? '0 : slot_pitch_in;

  always_comb begin
    status_word                = '0;
    status_word[VOICE_W]       = irq;
    status_word[VOICE_W-1:0]   = top_idx;
  end

  always_comb begin
    rd_data = '0;
    case (rd_kind)
      KIND_IE:   rd_data = ie_q[int'(rd_word)*DATA_W +: DATA_W];
      KIND_PEND: rd_data = pend_q[int'(rd_word)*DATA_W +: DATA_W];
      KIND_STEN: rd_data = sten_q[int'(rd_word)*DATA_W +: DATA_W];
      KIND_STOP: rd_data = stop_q[int'(rd_word)*DATA_W +: DATA_W];
      KIND_STAT: if (rd_word == '0) rd_data = status_word;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/vlc_loop_ctrl_chk.sv
module vlc_loop_ctrl_chk #(
  parameter int NUM_VOICES = 64,
  parameter int ADDR_W     = 24,
  parameter int PITCH_W    = 16,
  localparam int VOICE_W   = $clog2(NUM_VOICES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  slot_vld,
  input logic [VOICE_W-1:0]    slot_voice,
  input logic [ADDR_W-1:0]     slot_addr,
  input logic [ADDR_W-1:0]     slot_loop_end,
  input logic [PITCH_W-1:0]    slot_pitch_out,
  input logic                  slot_stopped,
  input logic                  wr_en,
  input logic                  irq,
  input logic [NUM_VOICES-1:0] ie_q,
  input logic [NUM_VOICES-1:0] pend_q,
  input logic [NUM_VOICES-1:0] sten_q,
  input logic [NUM_VOICES-1:0] stop_q,
  input logic [NUM_VOICES-1:0] loop_flags,
  input logic [VOICE_W-1:0]    top_idx
);

  assert_pend_on_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_addr >= slot_loop_end) |=> pend_q[$past(slot_voice)]);

  assert_pitch_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stopped |-> (slot_pitch_out == '0));

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !wr_en && stop_q[slot_voice]) |=> stop_q[$past(slot_voice)]);

  assert_stop_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_q & ~sten_q) == '0));

  assert_flag_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_addr < slot_loop_end) |=> !loop_flags[$past(slot_voice)]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q[top_idx] && ie_q[top_idx]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_vld && !wr_en) |=> ($stable(pend_q) && $stable(stop_q) && $stable(loop_flags)));

endmodule

bind vlc_loop_ctrl vlc_loop_ctrl_chk #(
  .NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_voice(slot_voice),
  .slot_addr(slot_addr), .slot_loop_end(slot_loop_end), .slot_pitch_out(slot_pitch_out),
  .slot_stopped(slot_stopped), .wr_en(wr_en), .irq(irq), .ie_q(ie_q), .pend_q(pend_q),
  .sten_q(sten_q), .stop_q(stop_q), .loop_flags(loop_flags), .top_idx(top_idx)
);

// File: tb/sim_vlc_loop_ctrl.sv
module sim_vlc_loop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {expected loop, voice[5:0], addr[23:0], loop_end[23:0]}
  localparam logic [54:0] VEC [NVEC] = '{
    {1'b1, 6'd0,  24'h000010, 24'h000010},
    {1'b0, 6'd63, 24'h00000F, 24'h000010},
    {1'b1, 6'd31, 24'hFFFFFF, 24'h000000},
    {1'b1, 6'd32, 24'h000000, 24'h000000},
    {1'b0, 6'd5,  24'h000100, 24'h000101},
    {1'b1, 6'd40, 24'hFFFFFF, 24'hFFFFFF},
    {1'b1, 6'd17, 24'h800000, 24'h7FFFFF},
    {1'b0, 6'd50, 24'h7FFFFF, 24'h800000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_vld;
  logic [5:0]  slot_voice;
  logic [23:0] slot_addr, slot_loop_end;
  logic [15:0] slot_pitch_in, slot_pitch_out;
  logic        slot_stopped;
  logic        wr_en;
  logic [3:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [63:0] loop_flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlc_loop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_voice(slot_voice),
    .slot_addr(slot_addr), .slot_loop_end(slot_loop_end), .slot_pitch_in(slot_pitch_in),
    .slot_pitch_out(slot_pitch_out), .slot_stopped(slot_stopped), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .loop_flags(loop_flags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_slot(input logic vld, input logic [5:0] v, input logic [23:0] a,
                         input logic [23:0] e, input logic [15:0] p);
    @(negedge clk);
    wr_en = 1'b0; slot_vld = vld; slot_voice = v;
    slot_addr = a; slot_loop_end = e; slot_pitch_in = p;
    #1;
  endtask

  task automatic do_write(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    slot_vld = 1'b0; wr_en = 1'b1; wr_sel = s; wr_data = d;
  endtask

  task automatic slot_and_write(input logic [5:0] v, input logic [23:0] a, input logic [23:0] e,
                                input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    slot_vld = 1'b1; slot_voice = v; slot_addr = a; slot_loop_end = e;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    slot_vld = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; slot_vld = 1'b0; slot_voice = '0; slot_addr = '0; slot_loop_end = '0;
    slot_pitch_in = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1: reset state
    for (int s = 0; s < 9; s++) begin
      rd(4'(s), d);
      check("R1 register", d, 32'h0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 flags lo", loop_flags[31:0], 32'd0);
    check("R1 flags hi", loop_flags[63:32], 32'd0);

    // R2 / R7: vector table through the loop compare
    for (int i = 0; i < NVEC; i++) begin
      logic        exp_hit;
      logic [5:0]  v;
      exp_hit = VEC[i][54];
      v       = VEC[i][53:48];
      do_slot(1'b1, v, VEC[i][47:24], VEC[i][23:0], 16'h4000);
      idle();
      rd(4'(2 + int'(v[5])), d);
      check("R2 pending bit", {31'd0, d[v[4:0]]}, {31'd0, exp_hit});
      check("R7 loop flag", {31'd0, loop_flags[v]}, {31'd0, exp_hit});
      do_write(4'd2, 32'hFFFF_FFFF);
      do_write(4'd3, 32'hFFFF_FFFF);
      idle();
    end

    // R11: slot without valid
    do_slot(1'b0, 6'd20, 24'h000200, 24'h000100, 16'h4000);
    idle();
    rd(4'd2, d);
    check("R11 pending untouched", d, 32'h0);
    check("R11 flag untouched", {31'd0, loop_flags[20]}, 32'd0);

    // R9: summary word and interrupt
    do_write(4'd0, 32'hFFFF_FFFF);
    do_write(4'd1, 32'hFFFF_FFFF);
    do_slot(1'b1, 6'd3, 24'h10, 24'h10, 16'h0);
    do_slot(1'b1, 6'd45, 24'h20, 24'h10, 16'h0);
    idle();
    rd(4'd8, d);
    check("R9 status two voices", d, 32'h0000_006D);
    check("R9 irq set", {31'd0, irq}, 32'd1);
    do_write(4'd3, 32'h0000_2000);
    idle();
    rd(4'd8, d);
    check("R9 status after clear", d, 32'h0000_0043);
    do_write(4'd0, 32'h0);
    idle();
    rd(4'd8, d);
    check("R9 status masked", d, 32'h0);
    check("R9 irq masked", {31'd0, irq}, 32'd0);

    // R8: write-one-to-clear semantics
    do_write(4'd2, 32'h0);
    idle();
    rd(4'd2, d);
    check("R8 zero write keeps", d, 32'h0000_0008);
    do_write(4'd2, 32'h0000_0008);
    idle();
    rd(4'd2, d);
    check("R8 one write clears", d, 32'h0);
    slot_and_write(6'd7, 24'h50, 24'h40, 4'd2, 32'h0000_0080);
    idle();
    rd(4'd2, d);
    check("R8 event wins over clear", d, 32'h0000_0080);
    do_write(4'd2, 32'h0000_0080);
    idle();

    // R3 / R4: stop on loop, voice 40 (hi word bit 8)
    do_write(4'd5, 32'h0000_0100);
    do_slot(1'b1, 6'd40, 24'h200, 24'h100, 16'h4000);
    check("R3 pitch forced in loop slot", {16'd0, slot_pitch_out}, 32'h0);
    check("R3 stopped flag", {31'd0, slot_stopped}, 32'd1);
    idle();
    rd(4'd7, d);
    check("R3 stop bit set", d, 32'h0000_0100);
    do_slot(1'b1, 6'd41, 24'h200, 24'h100, 16'h4000);
    check("R3 no enable passes pitch", {16'd0, slot_pitch_out}, 32'h0000_4000);
    idle();
    rd(4'd7, d);
    check("R3 no enable no stop", d, 32'h0000_0100);
    do_slot(1'b1, 6'd40, 24'h010, 24'h100, 16'h1234);
    check("R4 stop latched", {16'd0, slot_pitch_out}, 32'h0);
    idle();
    rd(4'd7, d);
    check("R4 stop survives address", d, 32'h0000_0100);
    do_write(4'd7, 32'h0);
    idle();
    rd(4'd7, d);
    check("R4 stop cleared by write", d, 32'h0);
    do_slot(1'b1, 6'd40, 24'h010, 24'h100, 16'h1234);
    check("R4 pitch resumes", {16'd0, slot_pitch_out}, 32'h0000_1234);
    do_slot(1'b1, 6'd40, 24'h300, 24'h100, 16'h1234);
    do_write(4'd5, 32'h0);
    idle();
    rd(4'd7, d);
    check("R4 stop cleared by enable", d, 32'h0);

    // R6: enable acts on the very next slot
    do_write(4'd4, 32'h0000_0004);
    do_slot(1'b1, 6'd2, 24'h80, 24'h40, 16'h2222);
    check("R6 new enable used", {16'd0, slot_pitch_out}, 32'h0);
    idle();
    rd(4'd6, d);
    check("R6 stop set after enable", d, 32'h0000_0004);
    do_write(4'd4, 32'h0);
    do_slot(1'b1, 6'd2, 24'h80, 24'h40, 16'h2222);
    check("R6 disable used", {16'd0, slot_pitch_out}, 32'h0000_2222);
    idle();
    rd(4'd6, d);
    check("R6 no stop after disable", d, 32'h0);

    // R5: software stop set masked by enable
    do_write(4'd4, 32'h0000_00F0);
    do_write(4'd6, 32'hFFFF_FFFF);
    do_write(4'd7, 32'hFFFF_FFFF);
    idle();
    rd(4'd6, d);
    check("R5 stop lo masked", d, 32'h0000_00F0);
    rd(4'd7, d);
    check("R5 stop hi masked", d, 32'h0);

    // R7: flag lifetime
    do_slot(1'b1, 6'd9, 24'h90, 24'h10, 16'h0);
    idle(); idle(); idle();
    check("R7 flag held", {31'd0, loop_flags[9]}, 32'd1);
    do_slot(1'b1, 6'd10, 24'h00, 24'h10, 16'h0);
    idle();
    check("R7 other slot keeps flag", {31'd0, loop_flags[9]}, 32'd1);
    check("R7 other voice no flag", {31'd0, loop_flags[10]}, 32'd0);
    do_slot(1'b1, 6'd9, 24'h00, 24'h10, 16'h0);
    idle();
    check("R7 flag dropped", {31'd0, loop_flags[9]}, 32'd0);

    // R10: unused selects
    do_write(4'd8, 32'hFFFF_FFFF);
    do_write(4'd15, 32'h0);
    do_write(4'd12, 32'h0);
    idle();
    rd(4'd1, d);
    check("R10 ie hi untouched", d, 32'hFFFF_FFFF);
    rd(4'd4, d);
    check("R10 sten lo untouched", d, 32'h0000_00F0);
    for (int s = 9; s < 16; s++) begin
      rd(4'(s), d);
      check("R10 unused read", d, 32'h0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule